// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block answers as a slave on a two-wire serial bus and fronts a byte-wide storage array of 256 locations, or 128 with a narrower address. It runs from the system clock. The raw clock and data lines are resynchronised and filtered, and a clean copy of each line goes to an edge and condition detector. A control finite-state machine then walks through the transfer: the selection byte, the word address, incoming data, and outgoing data. A separate datapath holds the shift register, the address pointer and the storage array. The control reaches the datapath only through a small bundle of single-cycle strobes.

The data line is driven open-drain. When `sdaOe` is high the pad pulls the line low, and when it is low the line is left to the pull-up. Each accepted data byte goes into the array at once. It is also reported to a neighbouring page-write timing controller, which sees every STOP as well. While that controller raises its busy flag, the slave acknowledges nothing, so a master can poll until the write cycle has finished.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START. A rising data line while the clock line is high is a STOP. Both are recognised in every state. A START always restarts decoding with a selection byte, and a byte cut short by it is discarded.
- R2: The first byte after START selects the slave when its bits 7..4 equal 1010. Bits 3..1 are ignored, and bit 0 gives the direction (1 read, 0 write). On any other code the slave does not acknowledge, stores nothing and keeps SDA released until the next START.
- R3: Each accepted byte is acknowledged: `sdaOe` goes high while SCL is low before the ninth clock pulse and stays high through that pulse. `sdaOe` only ever changes while SCL is low.
- R4: If `writeBusy` is high when a received byte completes, that byte gets no acknowledge and the rest of the transfer is ignored.
- R5: In a write transfer, the byte after the selection byte loads the pointer from its low address bits. Each later byte is stored at the pointer, reported as a one-cycle `wrByteValid` pulse with its address and value, and the pointer then advances by one.
- R6: A read that starts straight after the selection byte returns the byte at the pointer, which is the last accessed address plus one.
- R7: A write that carries only a word address, followed by a repeated START and a read selection byte, returns data from that word address.
- R8: In a read, a master acknowledge (SDA low on the ninth pulse) makes the slave send the byte at the next address. A master non-acknowledge releases SDA, and nothing more is sent until the next START.
- R9: The pointer wraps from its highest value to 0, for both writes and reads.
- R10: Every STOP produces exactly one one-cycle `stopEvt` pulse.
- R11: `sdaOe` is low during and after reset and whenever the slave is idle after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Level of the serial clock line |
| sdaIn | input | 1 | Level of the serial data line |
| writeBusy | input | 1 | Page-write controller is running an internal write cycle |
| sdaOe | output | 1 | 1 pulls the data line low |
| wrByteValid | output | 1 | One-cycle pulse for each stored data byte |
| wrByteAddr | output | ADDR_W | Address the byte was stored at |
| wrByteData | output | 8 | Value of the stored byte |
| stopEvt | output | 1 | One-cycle pulse for each STOP |

## Verification
The bench drives the bus with several kinds of transfer:
- a single-byte write;
- a multi-byte write whose don't-care selection bits are all set;
- an address-only write followed by a repeated START read;
- current-address reads after writes and after reads;
- foreign selection codes, transfers made while busy, a write across the top address, and a data byte aborted halfway by a START.

Each pattern separates one behaviour from its neighbours. The acknowledge bit distinguishes selection from rejection and busy from idle. The data returned shows whether the pointer was loaded, advanced or wrapped. The write reports and STOP pulses show whether a rejected or truncated byte had any effect.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    KIND_CTRL,
    KIND_ADDR,
    KIND_DATA
  } byteKind_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadPtr;
    logic incPtr;
    logic storeByte;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      stableCnt <= '0;
      cleanOut  <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != cleanOut) begin
        if (stableCnt == CNT_W'(FILT_LEN - 1)) begin
          cleanOut  <= syncQ[1];
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      writeBusy,
  input  logic      devHit,
  input  logic      rnwBit,
  input  logic      txBit,
  output dpStrobe_t strobe,
  output logic      sdaOe,
  output logic      stopEvt
);
  busState_t state, stateNxt;
  byteKind_t kind, kindNxt;
  logic [3:0] bitCnt, cntNxt;
  logic rnw, rnwNxt;
  logic sclQ, sdaQ;

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startCond = sclF & sclQ & sdaQ & ~sdaF;
  assign stopCond  = sclF & sclQ & ~sdaQ & sdaF;

  always_comb begin
    stateNxt = state;
    kindNxt  = kind;
    cntNxt   = bitCnt;
    rnwNxt   = rnw;
    strobe   = '0;
    if (stopCond) begin
      stateNxt = ST_IDLE;
    end else if (startCond) begin
      stateNxt = ST_RX;
      kindNxt  = KIND_CTRL;
      cntNxt   = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            strobe.shiftIn = 1'b1;
            cntNxt = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (writeBusy) begin
              stateNxt = ST_WAIT;
            end else if (kind == KIND_CTRL) begin
              if (devHit) begin
                stateNxt = ST_RXACK;
                rnwNxt   = rnwBit;
              end else begin
                stateNxt = ST_WAIT;
              end
            end else if (kind == KIND_ADDR) begin
              strobe.loadPtr = 1'b1;
              stateNxt = ST_RXACK;
            end else begin
              strobe.storeByte = 1'b1;
              strobe.incPtr    = 1'b1;
              stateNxt = ST_RXACK;
            end
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            cntNxt = '0;
            if (kind == KIND_CTRL && rnw) begin
              strobe.loadTx = 1'b1;
              stateNxt = ST_TX;
            end else begin
              stateNxt = ST_RX;
              kindNxt  = (kind == KIND_CTRL) ? KIND_ADDR : KIND_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            cntNxt = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              strobe.incPtr = 1'b1;
              stateNxt = ST_TXACK;
            end else begin
              strobe.shiftOut = 1'b1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise && sdaF) begin
            stateNxt = ST_WAIT;
          end else if (sclFall) begin
            strobe.loadTx = 1'b1;
            cntNxt = '0;
            stateNxt = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= KIND_CTRL;
      bitCnt  <= '0;
      rnw     <= 1'b0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      stopEvt <= 1'b0;
    end else begin
      state   <= stateNxt;
      kind    <= kindNxt;
      bitCnt  <= cntNxt;
      rnw     <= rnwNxt;
      sclQ    <= sclF;
      sdaQ    <= sdaF;
      stopEvt <= stopCond;
    end
  end

  // pull low for our acknowledge, or for a zero data bit while sending
  assign sdaOe = (state == ST_RXACK) | ((state == ST_TX) & ~txBit);
endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaF,
  input  dpStrobe_t         strobe,
  output logic              devHit,
  output logic              rnwBit,
  output logic              txBit,
  output logic              wrByteValid,
  output logic [ADDR_W-1:0] wrByteAddr,
  output logic [7:0]        wrByteData
);
  localparam int MEM_BYTES = 1 << ADDR_W;

  logic [7:0]        memArr [MEM_BYTES];
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        shiftReg;

  assign devHit = (shiftReg[7:4] == DEV_CODE);
  assign rnwBit = shiftReg[0];
  assign txBit  = shiftReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= '0;
      ptr         <= '0;
      shiftReg    <= '0;
      wrByteValid <= 1'b0;
      wrByteAddr  <= '0;
      wrByteData  <= '0;
    end else begin
      if (strobe.shiftIn)       shiftReg <= {shiftReg[6:0], sdaF};
      else if (strobe.shiftOut) shiftReg <= {shiftReg[6:0], 1'b1};
      else if (strobe.loadTx)   shiftReg <= memArr[ptr];

      if (strobe.loadPtr)     ptr <= shiftReg[ADDR_W-1:0];
      else if (strobe.incPtr) ptr <= ptr + 1'b1;

      if (strobe.storeByte) memArr[ptr] <= shiftReg;

      wrByteValid <= strobe.storeByte;
      if (strobe.storeByte) begin
        wrByteAddr <= ptr;
        wrByteData <= shiftReg;
      end
    end
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              writeBusy,
  output logic              sdaOe,
  output logic              wrByteValid,
  output logic [ADDR_W-1:0] wrByteAddr,
  output logic [7:0]        wrByteData,
  output logic              stopEvt
);
  logic [1:0] rawLines, cleanLines;
  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cs_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  dpStrobe_t strobe;
  logic devHit, rnwBit, txBit;

  i2cs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclF(cleanLines[0]), .sdaF(cleanLines[1]),
    .writeBusy(writeBusy), .devHit(devHit), .rnwBit(rnwBit), .txBit(txBit),
    .strobe(strobe), .sdaOe(sdaOe), .stopEvt(stopEvt)
  );

  i2cs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(cleanLines[1]), .strobe(strobe),
    .devHit(devHit), .rnwBit(rnwBit), .txBit(txBit),
    .wrByteValid(wrByteValid), .wrByteAddr(wrByteAddr), .wrByteData(wrByteData)
  );
endmodule

// File: rtl/eeprom_i2c_slave_checker.sv
module eeprom_i2c_slave_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic stopEvt,
  input logic wrByteValid,
  input logic writeBusy
);
  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  assert_no_ack_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (writeBusy && $past(writeBusy)) |-> !$rose(sdaOe));

  assert_no_store_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid |-> !$past(writeBusy));

  assert_store_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrByteValid |=> !wrByteValid);

  assert_stop_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !stopEvt);

  assert_release_after_stop_R11: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |-> !sdaOe);

  always @(posedge clk) begin
    if (!rstN) assert_reset_release_R11: assert (!sdaOe);
  end
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_checker u_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .stopEvt(stopEvt), .wrByteValid(wrByteValid), .writeBusy(writeBusy)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic writeBusy = 1'b0;
  logic sdaOe, wrByteValid, stopEvt;
  logic [7:0] wrByteAddr, wrByteData;
  logic sdaLine;

  assign sdaLine = mSda & ~sdaOe;

  always #5 clk = ~clk;

  eeprom_i2c_slave u_eeprom_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .writeBusy(writeBusy),
    .sdaOe(sdaOe), .wrByteValid(wrByteValid), .wrByteAddr(wrByteAddr),
    .wrByteData(wrByteData), .stopEvt(stopEvt)
  );

  int checks = 0;
  int fails = 0;
  int stopsSent = 0;
  int stopsSeen = 0;
  bit finished = 0;

  string expTagQ[$];
  int    expValQ[$];
  int    obsValQ[$];
  int    wrLogQ[$];

  task automatic checkEq(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pairs every observed bus result with the oldest expectation
  initial forever begin
    @(negedge clk);
    while (obsValQ.size() > 0) begin
      int v;
      int e;
      string t;
      v = obsValQ.pop_front();
      t = expTagQ.pop_front();
      e = expValQ.pop_front();
      checkEq(t, v, e);
    end
  end

  initial forever begin
    @(negedge clk);
    if (wrByteValid) wrLogQ.push_back({16'd0, wrByteAddr, wrByteData});
    if (stopEvt) stopsSeen++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; tick(Q); scl = 1'b1; tick(Q); mSda = 1'b1; tick(Q);
    stopsSent++;
  endtask

  task automatic sendBit(input logic b);
    mSda = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sdaLine; tick(Q); scl = 1'b0; tick(Q);
  endtask

  // expected ack bit: 0 = slave acknowledged, 1 = no acknowledge
  task automatic sendByte(input logic [7:0] d, input int expAck, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    expTagQ.push_back({tag, " ack"});
    expValQ.push_back(expAck);
    getBit(a);
    obsValQ.push_back(int'(a));
  endtask

  task automatic recvByte(input logic [7:0] exp, input logic masterAck, input string tag);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      logic b;
      getBit(b);
      d[i] = b;
    end
    expTagQ.push_back({tag, " data"});
    expValQ.push_back(int'(exp));
    obsValQ.push_back(int'(d));
    sendBit(masterAck ? 1'b0 : 1'b1);
  endtask

  task automatic checkWr(input string tag, input int addr, input int data);
    if (wrLogQ.size() == 0) checkEq(tag, -1, (addr << 8) | data);
    else checkEq(tag, wrLogQ.pop_front(), (addr << 8) | data);
  endtask

  initial begin
    tick(200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(5);
    checkEq("R11 reset release", int'(sdaOe), 0);
    rstN = 1'b1;
    tick(10);

    // single byte write
    busStart();
    sendByte(8'hA0, 0, "R3 select write");
    sendByte(8'h10, 0, "R5 word address");
    sendByte(8'h5A, 0, "R5 data byte");
    busStop();
    checkWr("R5 byte report", 'h10, 'h5A);
    checkEq("R10 stop count", stopsSeen, stopsSent);

    // multi-byte write, don't-care select bits all set
    busStart();
    sendByte(8'hAE, 0, "R2 select bits ignored");
    sendByte(8'h20, 0, "R5 word address");
    sendByte(8'h11, 0, "R5 data");
    sendByte(8'h22, 0, "R5 data");
    sendByte(8'h33, 0, "R5 data");
    sendByte(8'h44, 0, "R5 data");
    busStop();
    checkWr("R5 consecutive", 'h20, 'h11);
    checkWr("R5 consecutive", 'h21, 'h22);
    checkWr("R5 consecutive", 'h22, 'h33);
    checkWr("R5 consecutive", 'h23, 'h44);

    // random read then sequential continuation
    busStart();
    sendByte(8'hA0, 0, "R7 select");
    sendByte(8'h20, 0, "R7 address only");
    busStart();
    sendByte(8'hA1, 0, "R7 read select");
    recvByte(8'h11, 1'b1, "R7 random read");
    recvByte(8'h22, 1'b1, "R8 sequential");
    recvByte(8'h33, 1'b0, "R8 sequential last");
    tick(Q);
    checkEq("R8 released after nack", int'(sdaOe), 0);
    busStop();

    // current-address read
    busStart();
    sendByte(8'hA1, 0, "R6 select read");
    recvByte(8'h44, 1'b0, "R6 current address");
    busStop();

    // foreign select code: nothing acknowledged, nothing stored
    busStart();
    sendByte(8'hB0, 1, "R2 foreign code");
    sendByte(8'h10, 1, "R2 ignored address");
    sendByte(8'h00, 1, "R2 ignored data");
    busStop();
    checkEq("R2 no store report", wrLogQ.size(), 0);
    busStart();
    sendByte(8'hA0, 0, "R2 select");
    sendByte(8'h10, 0, "R2 address");
    busStart();
    sendByte(8'hA1, 0, "R2 read select");
    recvByte(8'h5A, 1'b0, "R2 location unchanged");
    busStop();

    // busy: acknowledges withheld
    writeBusy = 1'b1;
    tick(4);
    busStart();
    sendByte(8'hA0, 1, "R4 busy write select");
    sendByte(8'h00, 1, "R4 busy data");
    busStop();
    busStart();
    sendByte(8'hA1, 1, "R4 busy read select");
    busStop();
    checkEq("R4 no store while busy", wrLogQ.size(), 0);
    writeBusy = 1'b0;
    tick(4);
    busStart();
    sendByte(8'hA1, 0, "R4 ack after busy");
    recvByte(8'h00, 1'b0, "R6 pointer after read");
    busStop();

    // wrap of the pointer at the top address
    busStart();
    sendByte(8'hA0, 0, "R9 select");
    sendByte(8'hFF, 0, "R9 top address");
    sendByte(8'h77, 0, "R9 data");
    sendByte(8'h88, 0, "R9 data");
    busStop();
    checkWr("R9 write top", 'hFF, 'h77);
    checkWr("R9 write wrapped", 'h00, 'h88);
    busStart();
    sendByte(8'hA0, 0, "R9 select");
    sendByte(8'hFF, 0, "R9 address");
    busStart();
    sendByte(8'hA1, 0, "R9 read select");
    recvByte(8'h77, 1'b1, "R9 read top");
    recvByte(8'h88, 1'b0, "R9 read wrapped");
    busStop();

    // START in the middle of a data byte
    busStart();
    sendByte(8'hA0, 0, "R1 select");
    sendByte(8'h30, 0, "R1 address");
    sendByte(8'h3C, 0, "R1 data");
    busStop();
    checkWr("R1 setup write", 'h30, 'h3C);
    busStart();
    sendByte(8'hA0, 0, "R1 select");
    sendByte(8'h30, 0, "R1 address");
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStart();
    sendByte(8'hA1, 0, "R1 restart read select");
    recvByte(8'h3C, 1'b0, "R1 partial byte dropped");
    busStop();
    checkEq("R1 no store from partial byte", wrLogQ.size(), 0);

    tick(10);
    checkEq("R10 stop count", stopsSeen, stopsSent);
    checkEq("R11 idle release", int'(sdaOe), 0);
    tick(5);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule